// File: doc/BRIEF.md
# Slot Mailbox with One-Hot Slot State

This block is a register-mapped mailbox shared by a host processor and a peer controller. It holds a set of numbered slots. Each slot has a mode word and a fixed eight-word message buffer. The host reaches everything through one word-wide register port. A region select input chooses between the slot space and a small interrupt register space. The peer has its own port. Through it the peer writes and reads message words, delivers a message into a slot, reports completion of a transmit, and clears the doorbell bits raised toward it. Data moves only by register access.

Each slot runs a four-state machine whose encoding is visible in bits 7:4 of its mode word. The states are IDLE (0x1), TX (0x2), RX (0x4) and ACK (0x8). The transitions are:
- host state write: any state to the written one-hot code;
- peer delivery: any state to RX;
- peer completion in TX: to IDLE when mode bit 0 is 1, which is automatic return to idle, or to ACK when mode bit 0 is 0, which is interrupt acknowledge.

Peer delivery and an interrupt-mode completion each set that slot's acknowledge raw bit, bit m for slot m. The raw bits are ANDed with an enable vector and collapsed into one local interrupt line. A separate doorbell vector, set by the host, drives the interrupt lines toward the peer.

Top module: `slot_mbox`

## Requirements
- R1: After reset every slot is IDLE with mode bit 0 cleared and all message words zero. The acknowledge raw, enable and doorbell vectors are zero, and `ack_irq` is low.
- R2: In the slot region (`h_ipc`=0), slot m starts at byte 0x40*m. Its mode word is at offset 0x0 and message word k (0..7) is at offset 0x4+4k. The mode word reads the state in bits 7:4 and mode bit 0, with all other bits zero. Offsets 0x24 to 0x3C read zero and ignore writes.
- R3: A mode-word write whose bits 7:4 hold one of the one-hot codes 0x1, 0x2, 0x4 or 0x8 replaces the state and leaves mode bit 0 unchanged.
- R4: A mode-word write with bits 7:4 equal to zero loads mode bit 0 from data bit 0 and keeps the state. A write whose bits 7:4 are nonzero but not one-hot changes nothing.
- R5: The peer completion op (`peer_op`=3) on a slot in TX with mode bit 0 set moves it to IDLE and sets no acknowledge raw bit.
- R6: A completion on a slot in TX with mode bit 0 clear moves it to ACK and sets raw bit m. A completion on a slot in any other state has no effect.
- R7: Peer write (`peer_op`=1) stores `peer_wdata` in the selected message word, and peer delivery (`peer_op`=2) moves the slot to RX and sets raw bit m. `peer_rdata` shows the selected word. In the same cycle, a peer state change overrides a host state write to that slot, and a peer word write overrides a host write to the same word.
- R8: In the interrupt region (`h_ipc`=1), writing 1s at 0x500 sets enable bits and writing 1s at 0x504 clears them. A write at 0x404 replaces the enable vector, and 0x404 reads it back. 0x400 reads raw and 0x408 reads raw AND enable. `ack_irq` is high exactly when that AND is nonzero.
- R9: Writing 1s at 0x40C clears raw bits, and writing 1s at 0x400 sets them. A peer-side set in the same cycle wins over a clear.
- R10: Writing 1s at 0x420 sets doorbell bits, which appear on `dst_irq` and read back at 0x420. `peer_dst_clr` clears bits, and a host set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host write strobe |
| h_ipc | input | 1 | Host region select: 0 slots, 1 interrupt registers |
| h_addr | input | 11 | Host byte address within the region |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for `h_ipc`/`h_addr`, combinational |
| peer_op | input | 2 | Peer op: 0 none, 1 word write, 2 deliver, 3 complete |
| peer_slot | input | 5 | Slot addressed by the peer |
| peer_word | input | 3 | Message word addressed by the peer |
| peer_wdata | input | 32 | Peer write data |
| peer_rdata | output | 32 | Message word selected by `peer_slot`/`peer_word` |
| peer_dst_clr | input | 32 | One bits clear doorbell bits |
| dst_irq | output | 32 | Doorbell interrupt vector toward the peer |
| ack_irq | output | 1 | Combined acknowledge interrupt toward the host |

## Verification
The assertions take three things for granted. The peer issues at most one op per cycle, which its encoded op field enforces. The host issues at most one write per cycle, so enable, disable and mask updates never collide. The slot count is no larger than the data width. The stimulus respects all three by construction. It does deliberately line up a host state write or raw clear with a peer event on the same slot, so that the stated priorities are exercised. Random mode-word data draws the state field from the four valid codes, zero, and one non-one-hot value, so that both kinds of ignored write are reached.

// File: rtl/slot_mbox_pkg.sv
package slot_mbox_pkg;

    typedef enum logic [3:0] {
        ST_IDLE = 4'h1,
        ST_TX   = 4'h2,
        ST_RX   = 4'h4,
        ST_ACK  = 4'h8
    } slot_state_t;

    typedef enum logic [1:0] {
        PEER_NONE     = 2'd0,
        PEER_WRITE    = 2'd1,
        PEER_DELIVER  = 2'd2,
        PEER_COMPLETE = 2'd3
    } peer_op_t;

    localparam int STATE_LSB = 4;
    localparam int STATE_W   = 4;
    localparam int AUTO_BIT  = 0;

    localparam int OFF_RAW = 'h400;
    localparam int OFF_MSK = 'h404;
    localparam int OFF_STA = 'h408;
    localparam int OFF_CLR = 'h40C;
    localparam int OFF_DST = 'h420;
    localparam int OFF_ENA = 'h500;
    localparam int OFF_DIS = 'h504;

endpackage

// File: rtl/slot_mbox_slot.sv
module slot_mbox_slot
    import slot_mbox_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MSG_WORDS = 8,
    parameter int IDX_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_mode_we,
    input  logic              host_msg_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              peer_msg_we,
    input  logic [IDX_W-1:0]  peer_idx,
    input  logic [DATA_W-1:0] peer_wdata,
    input  logic              peer_deliver,
    input  logic              peer_complete,
    output logic [DATA_W-1:0] mode_word,
    output logic [DATA_W-1:0] msg_o [MSG_WORDS],
    output logic              ack_evt
);

    slot_state_t         state_q, state_d;
    logic                auto_q;
    logic [STATE_W-1:0]  wr_field;
    logic                field_zero, field_valid, host_state_wr;

    assign wr_field      = host_wdata[STATE_LSB +: STATE_W];
    assign field_zero    = (wr_field == '0);
    assign field_valid   = ($countones(wr_field) == 1);
    assign host_state_wr = host_mode_we && field_valid;

    // next state; peer events override a host state write
    always_comb begin
        state_d = state_q;
        ack_evt = 1'b0;
        if (peer_deliver) begin
            state_d = ST_RX;
            ack_evt = 1'b1;
        end else if (peer_complete && state_q == ST_TX) begin
            if (auto_q) begin
                state_d = ST_IDLE;
            end else begin
                state_d = ST_ACK;
                ack_evt = 1'b1;
            end
        end else if (host_state_wr) begin
            unique case (wr_field)
                4'h1:    state_d = ST_IDLE;
                4'h2:    state_d = ST_TX;
                4'h4:    state_d = ST_RX;
                default: state_d = ST_ACK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            auto_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (host_mode_we && field_zero)
                auto_q <= host_wdata[AUTO_BIT];
        end
    end

    always_comb begin
        mode_word                        = '0;
        mode_word[STATE_LSB +: STATE_W]  = state_q;
        mode_word[AUTO_BIT]              = auto_q;
    end

    for (genvar k = 0; k < MSG_WORDS; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                msg_o[k] <= '0;
            else if (peer_msg_we && peer_idx == IDX_W'(k))
                msg_o[k] <= peer_wdata;
            else if (host_msg_we && host_idx == IDX_W'(k))
                msg_o[k] <= host_wdata;
        end
    end

    p_state_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);

    p_state_wr_keeps_auto_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode_we && !field_zero |=> $stable(auto_q));

    p_auto_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        peer_complete && state_q == ST_TX && auto_q |=> state_q == ST_IDLE);

    p_complete_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        peer_complete && state_q != ST_TX && !host_mode_we |=> $stable(state_q));

    p_deliver_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        peer_deliver |=> state_q == ST_RX);

endmodule

// File: rtl/slot_mbox_ipc.sv
module slot_mbox_ipc
    import slot_mbox_pkg::*;
#(
    parameter int N      = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_off,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [N-1:0]      ack_set,
    input  logic [N-1:0]      dst_clr,
    output logic [DATA_W-1:0] rdata,
    output logic [N-1:0]      dst_o,
    output logic              irq_o
);

    logic [N-1:0] raw_q, en_q, dst_q;
    logic [N-1:0] wbits;
    logic         wr_raw, wr_msk, wr_clr, wr_dst, wr_ena, wr_dis;

    assign wbits  = host_wdata[N-1:0];
    assign wr_raw = host_we && host_off == ADDR_W'(OFF_RAW);
    assign wr_msk = host_we && host_off == ADDR_W'(OFF_MSK);
    assign wr_clr = host_we && host_off == ADDR_W'(OFF_CLR);
    assign wr_dst = host_we && host_off == ADDR_W'(OFF_DST);
    assign wr_ena = host_we && host_off == ADDR_W'(OFF_ENA);
    assign wr_dis = host_we && host_off == ADDR_W'(OFF_DIS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
            en_q  <= '0;
            dst_q <= '0;
        end else begin
            raw_q <= (raw_q & ~(wr_clr ? wbits : '0))
                   | (wr_raw ? wbits : '0) | ack_set;
            dst_q <= (dst_q & ~dst_clr) | (wr_dst ? wbits : '0);
            if (wr_msk)
                en_q <= wbits;
            else if (wr_ena)
                en_q <= en_q | wbits;
            else if (wr_dis)
                en_q <= en_q & ~wbits;
        end
    end

    assign dst_o = dst_q;
    assign irq_o = |(raw_q & en_q);

    always_comb begin
        rdata = '0;
        if (host_off == ADDR_W'(OFF_RAW))      rdata = DATA_W'(raw_q);
        else if (host_off == ADDR_W'(OFF_MSK)) rdata = DATA_W'(en_q);
        else if (host_off == ADDR_W'(OFF_STA)) rdata = DATA_W'(raw_q & en_q);
        else if (host_off == ADDR_W'(OFF_DST)) rdata = DATA_W'(dst_q);
    end

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_set != '0 |=> (raw_q & $past(ack_set)) == $past(ack_set));

    p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dis |=> (en_q & $past(wbits)) == '0);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr && ack_set == '0 |=> (raw_q & $past(wbits)) == '0);

    p_doorbell_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dst |=> (dst_q & $past(wbits)) == $past(wbits));

endmodule

// File: rtl/slot_mbox.sv
module slot_mbox
    import slot_mbox_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int MSG_WORDS = 8,
    parameter int DATA_W    = 32,
    localparam int SEL_W    = $clog2(NUM_SLOTS),
    localparam int IDX_W    = $clog2(MSG_WORDS),
    localparam int SLOT_AW  = $clog2((MSG_WORDS + 1) * 4),
    localparam int ADDR_W   = (SLOT_AW + SEL_W > 11) ? SLOT_AW + SEL_W : 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic              h_ipc,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [1:0]        peer_op,
    input  logic [SEL_W-1:0]  peer_slot,
    input  logic [IDX_W-1:0]  peer_word,
    input  logic [DATA_W-1:0] peer_wdata,
    output logic [DATA_W-1:0] peer_rdata,
    input  logic [NUM_SLOTS-1:0] peer_dst_clr,
    output logic [NUM_SLOTS-1:0] dst_irq,
    output logic              ack_irq
);

    localparam int WI_W = SLOT_AW - 2;

    peer_op_t               pop;
    logic [SEL_W-1:0]       h_sel;
    logic [WI_W-1:0]        h_widx;
    logic [IDX_W-1:0]       h_midx;
    logic                   h_is_mode, h_is_msg;
    logic [DATA_W-1:0]      mode_all [NUM_SLOTS];
    logic [DATA_W-1:0]      msg_all  [NUM_SLOTS][MSG_WORDS];
    logic [NUM_SLOTS-1:0]   ack_all;
    logic [DATA_W-1:0]      ipc_rdata;

    assign pop       = peer_op_t'(peer_op);
    assign h_sel     = h_addr[SLOT_AW +: SEL_W];
    assign h_widx    = h_addr[2 +: WI_W];
    assign h_midx    = IDX_W'(h_widx - WI_W'(1));
    assign h_is_mode = (h_widx == '0);
    assign h_is_msg  = (h_widx != '0) && (h_widx <= WI_W'(MSG_WORDS));

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic hit, peer_hit;
        assign hit      = h_we && !h_ipc && h_sel == SEL_W'(g);
        assign peer_hit = peer_slot == SEL_W'(g);

        slot_mbox_slot #(
            .DATA_W   (DATA_W),
            .MSG_WORDS(MSG_WORDS),
            .IDX_W    (IDX_W)
        ) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .host_mode_we (hit && h_is_mode),
            .host_msg_we  (hit && h_is_msg),
            .host_idx     (h_midx),
            .host_wdata   (h_wdata),
            .peer_msg_we  (peer_hit && pop == PEER_WRITE),
            .peer_idx     (peer_word),
            .peer_wdata   (peer_wdata),
            .peer_deliver (peer_hit && pop == PEER_DELIVER),
            .peer_complete(peer_hit && pop == PEER_COMPLETE),
            .mode_word    (mode_all[g]),
            .msg_o        (msg_all[g]),
            .ack_evt      (ack_all[g])
        );
    end

    slot_mbox_ipc #(
        .N     (NUM_SLOTS),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_ipc (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (h_we && h_ipc),
        .host_off  (h_addr),
        .host_wdata(h_wdata),
        .ack_set   (ack_all),
        .dst_clr   (peer_dst_clr),
        .rdata     (ipc_rdata),
        .dst_o     (dst_irq),
        .irq_o     (ack_irq)
    );

    always_comb begin
        h_rdata = '0;
        if (h_ipc)          h_rdata = ipc_rdata;
        else if (h_is_mode) h_rdata = mode_all[h_sel];
        else if (h_is_msg)  h_rdata = msg_all[h_sel][h_midx];
    end

    assign peer_rdata = msg_all[peer_slot][peer_word];

endmodule

// File: tb/slot_mbox_tb.sv
module slot_mbox_tb;

    localparam int N  = 32;
    localparam int MW = 8;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          h_we, h_ipc;
    logic [AW-1:0] h_addr;
    logic [31:0]   h_wdata, h_rdata;
    logic [1:0]    peer_op;
    logic [4:0]    peer_slot;
    logic [2:0]    peer_word;
    logic [31:0]   peer_wdata, peer_rdata;
    logic [N-1:0]  peer_dst_clr, dst_irq;
    logic          ack_irq;

    always #10 clk = ~clk;

    slot_mbox u_dut (
        .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_ipc(h_ipc), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .peer_op(peer_op),
        .peer_slot(peer_slot), .peer_word(peer_word), .peer_wdata(peer_wdata),
        .peer_rdata(peer_rdata), .peer_dst_clr(peer_dst_clr),
        .dst_irq(dst_irq), .ack_irq(ack_irq)
    );

    logic [3:0]  m_st   [N];
    logic        m_auto [N];
    logic [31:0] m_msg  [N][MW];
    logic [31:0] m_raw, m_en, m_dst;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic ipc, input logic [AW-1:0] a);
        int s, w;
        if (ipc) begin
            case (int'(a))
                'h400:   return m_raw;
                'h404:   return m_en;
                'h408:   return m_raw & m_en;
                'h420:   return m_dst;
                default: return 32'h0;
            endcase
        end
        s = int'(a[10:6]);
        w = int'(a[5:2]);
        if (w == 0) return {24'h0, m_st[s], 3'b000, m_auto[s]};
        if (w <= MW) return m_msg[s][w-1];
        return 32'h0;
    endfunction

    task automatic model_update();
        logic [31:0] hset, hclr, dset, pset;
        logic [3:0]  f;
        int s, w, ps;
        logic [3:0]  old_st;
        logic        old_auto;
        hset = 0; hclr = 0; dset = 0; pset = 0;
        ps = int'(peer_slot);
        old_st = m_st[ps];
        old_auto = m_auto[ps];
        if (h_we && !h_ipc) begin
            s = int'(h_addr[10:6]);
            w = int'(h_addr[5:2]);
            if (w == 0) begin
                f = h_wdata[7:4];
                if (f == 0) m_auto[s] = h_wdata[0];
                else if ($countones(f) == 1) m_st[s] = f;
            end else if (w <= MW) begin
                if (!(peer_op == 2'd1 && ps == s && int'(peer_word) == w - 1))
                    m_msg[s][w-1] = h_wdata;
            end
        end
        if (h_we && h_ipc) begin
            case (int'(h_addr))
                'h400: hset = h_wdata;
                'h404: m_en = h_wdata;
                'h40C: hclr = h_wdata;
                'h420: dset = h_wdata;
                'h500: m_en = m_en | h_wdata;
                'h504: m_en = m_en & ~h_wdata;
                default: ;
            endcase
        end
        case (peer_op)
            2'd1: m_msg[ps][peer_word] = peer_wdata;
            2'd2: begin m_st[ps] = 4'h4; pset[ps] = 1'b1; end
            2'd3: if (old_st == 4'h2) begin
                if (old_auto) m_st[ps] = 4'h1;
                else begin m_st[ps] = 4'h8; pset[ps] = 1'b1; end
            end
            default: ;
        endcase
        m_raw = (m_raw & ~hclr) | hset | pset;
        m_dst = (m_dst & ~peer_dst_clr) | dset;
    endtask

    task automatic tick();
        model_update();
        @(posedge clk);
        @(negedge clk);
        h_we = 0; peer_op = 0; peer_dst_clr = 0;
        #1;
        check("R8 ack_irq", {31'b0, ack_irq}, {31'b0, |(m_raw & m_en)});
        check("R10 dst_irq", dst_irq, m_dst);
    endtask

    task automatic hw(input logic ipc, input int a, input logic [31:0] d);
        h_we = 1; h_ipc = ipc; h_addr = AW'(a); h_wdata = d;
        tick();
    endtask

    task automatic pe(input int op, input int s, input int w, input logic [31:0] d);
        peer_op = 2'(op); peer_slot = 5'(s); peer_word = 3'(w); peer_wdata = d;
        tick();
    endtask

    task automatic rd(input logic ipc, input int a, input string tag);
        h_ipc = ipc; h_addr = AW'(a);
        #1;
        check(tag, h_rdata, exp_rd(ipc, AW'(a)));
    endtask

    task automatic rdx(input logic ipc, input int a, input logic [31:0] exp, input string tag);
        h_ipc = ipc; h_addr = AW'(a);
        #1;
        check(tag, h_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ipc_offs [7];
        ipc_offs = '{'h400, 'h404, 'h408, 'h40C, 'h420, 'h500, 'h504};
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_st[i] = 4'h1; m_auto[i] = 0;
            for (int k = 0; k < MW; k++) m_msg[i][k] = 0;
        end
        m_raw = 0; m_en = 0; m_dst = 0;
        rst_n = 0; h_we = 0; h_ipc = 0; h_addr = 0; h_wdata = 0;
        peer_op = 0; peer_slot = 0; peer_word = 0; peer_wdata = 0; peer_dst_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        rdx(0, 'h000, 32'h10, "R1 slot0 mode");
        rdx(0, 'h7E0, 32'h0, "R1 slot31 word7");
        rdx(1, 'h400, 32'h0, "R1 raw");
        rdx(1, 'h404, 32'h0, "R1 enable");
        rdx(1, 'h420, 32'h0, "R1 doorbell");
        check("R1 ack_irq", {31'b0, ack_irq}, 32'h0);
        // R4 mode write, R3 state write
        hw(0, 'h0C0, 32'h01);  rdx(0, 'h0C0, 32'h11, "R4 mode bit set");
        hw(0, 'h0C0, 32'h20);  rdx(0, 'h0C0, 32'h21, "R3 state write keeps bit0");
        hw(0, 'h0C0, 32'h61);  rdx(0, 'h0C0, 32'h21, "R4 invalid code ignored");
        hw(0, 'h0C0, 32'h00);  rdx(0, 'h0C0, 32'h20, "R4 mode clear keeps state");
        hw(0, 'h0C0, 32'h01);
        // R5 automatic completion
        pe(3, 3, 0, 0);        rdx(0, 'h0C0, 32'h11, "R5 auto to idle");
        rdx(1, 'h400, 32'h0, "R5 no raw bit");
        // R6 interrupt completion
        hw(0, 'h140, 32'h20);
        hw(1, 'h500, 32'h20);
        pe(3, 5, 0, 0);        rdx(0, 'h140, 32'h80, "R6 to ack");
        rdx(1, 'h400, 32'h20, "R6 raw bit5");
        rdx(1, 'h408, 32'h20, "R8 status");
        pe(3, 5, 0, 0);        rdx(0, 'h140, 32'h80, "R6 completion in ack ignored");
        // R9 clear
        hw(1, 'h40C, 32'h20);  rdx(1, 'h400, 32'h0, "R9 clear");
        // R7 peer write and delivery
        pe(1, 7, 2, 32'hCAFE0002); rdx(0, 'h1CC, 32'hCAFE0002, "R7 peer word write");
        pe(2, 7, 0, 0);        rdx(0, 'h1C0, 32'h40, "R7 deliver to rx");
        rdx(1, 'h400, 32'h80, "R7 deliver raw bit7");
        hw(0, 'h1C4, 32'h12345678);
        peer_slot = 7; peer_word = 0; #1;
        check("R7 peer_rdata", peer_rdata, 32'h12345678);
        // R8 enable, mask, disable
        hw(1, 'h404, 32'hFFFF0000); rdx(1, 'h404, 32'hFFFF0000, "R8 mask replace");
        hw(1, 'h504, 32'h00FF0000); rdx(1, 'h404, 32'hFF000000, "R8 disable");
        hw(1, 'h500, 32'h80);  rdx(1, 'h408, 32'h80, "R8 enable status");
        // R9 set wins over clear
        h_we = 1; h_ipc = 1; h_addr = 'h40C; h_wdata = 32'h80;
        pe(2, 7, 0, 0);        rdx(1, 'h400, 32'h80, "R9 peer set wins");
        hw(1, 'h40C, 32'h80);
        // R7 peer overrides host state write
        hw(0, 'h240, 32'h20);
        h_we = 1; h_ipc = 0; h_addr = 'h240; h_wdata = 32'h40;
        pe(3, 9, 0, 0);        rdx(0, 'h240, 32'h80, "R7 peer over host");
        rdx(1, 'h400, 32'h200, "R6 raw bit9");
        // R10 doorbell
        hw(1, 'h420, 32'h5);   rdx(1, 'h420, 32'h5, "R10 doorbell set");
        h_we = 1; h_ipc = 1; h_addr = 'h420; h_wdata = 32'h1; peer_dst_clr = 32'h1;
        tick();                rdx(1, 'h420, 32'h5, "R10 host set wins");
        peer_dst_clr = 32'h4; tick(); rdx(1, 'h420, 32'h1, "R10 peer clear");
        // R2 layout
        hw(0, 'h0B0, 32'hDEAD); rdx(0, 'h0B0, 32'h0, "R2 unused offset");
        hw(0, 'h7C4, 32'hABCD); rdx(0, 'h7C4, 32'hABCD, "R2 slot31 word0");
        rdx(0, 'h784, 32'h0, "R2 slot30 word0 untouched");
        // random phase
        for (int it = 0; it < 3000; it++) begin
            int kind;
            kind = int'($urandom % 8);
            if (kind < 4 || kind == 7) begin
                if ($urandom % 3 == 0) begin
                    logic [3:0] fld;
                    int fsel;
                    fsel = int'($urandom % 6);
                    fld = (fsel == 5) ? 4'h3 : (fsel == 0 ? 4'h0 : 4'(1 << (fsel - 1)));
                    h_we = 1; h_ipc = 0;
                    h_addr = {5'($urandom % N), 4'h0, 2'b00};
                    h_wdata = {$urandom, fld, 3'b000, 1'($urandom)} ;
                end else if ($urandom % 2 == 0) begin
                    h_we = 1; h_ipc = 0;
                    h_addr = {5'($urandom % N), 4'($urandom), 2'b00};
                    h_wdata = $urandom;
                end else begin
                    h_we = 1; h_ipc = 1;
                    h_addr = AW'(ipc_offs[$urandom % 7]);
                    h_wdata = $urandom;
                end
            end
            if (kind >= 4) begin
                peer_op = 2'($urandom);
                peer_slot = 5'($urandom);
                peer_word = 3'($urandom);
                peer_wdata = $urandom;
                if ($urandom % 4 == 0) peer_dst_clr = $urandom;
            end
            tick();
            if ($urandom % 2 == 0)
                rd(0, int'({5'($urandom % N), 4'($urandom), 2'b00}), "R2 random slot read");
            else
                rd(1, ipc_offs[$urandom % 7], "R8 random interrupt register read");
            peer_slot = 5'($urandom); peer_word = 3'($urandom); #1;
            check("R7 random peer_rdata", peer_rdata, m_msg[peer_slot][peer_word]);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule